// File: doc/BRIEF.md
# Multi-word multiply index sequencer

This block walks a two-level loop and, on every step, names three vector elements: an element of operand A, an element of operand B, and the element of the product or accumulator that the partial result lands in. A vector unit doing schoolbook multi-word multiplication follows these triples one after another. The same counters also produce the row-rotated (modulo) pattern and triangular prefix patterns. Inversion and mirroring bits reorder the traversal.

A `start` pulse latches a configuration word and rewinds the counters. Each `step` pulse advances to the next triple. Between steps the outputs hold their value. `done` rises together with the final valid triple and stays high until the next `start`.

Configuration word layout (LSB-0), with `DW` = 6 by default:
- `[DW-1:0]` holds the outer size minus one (A).
- `[2DW-1:DW]` holds the inner size minus one (B).
- `[2DW+4:2DW]` holds the submode.
- `[2DW+6:2DW+5]` holds the pattern class, which must be 2'b10.
- `[2DW+7]` is the multiply-family select, which must be 1.

Submode bits:
- Bit 0: 1 selects the rhombus (multiply) pattern, 0 selects the triangular prefix pattern.
- Bit 1: modulo third index; valid in rhombus only.
- Bit 2: invert.
- Bit 3: mirror X.
- Bit 4: mirror Y.

Top module: `bigmul_remap_seq`

## Requirements
- R1: After reset, `valid` and `done` are 0. A `start` pulse latches the word, and the first triple is shown with `valid`=1 in the next cycle.
- R2: Rhombus pattern (bit0=1, bit1=0): the outer index i runs 0..A-1, and for each i the inner index j runs 0..B-1. The outputs are a=i, b=j and p=i+j, with p one bit wider than a and b.
- R3: With submode bit1=1 in the rhombus pattern, p=(i+j) mod B.
- R4: In the rhombus pattern, bit2 reverses both the outer and the inner order. Bit4 toggles the outer direction again and bit3 toggles the inner direction again, so outer descends when bit2 XOR bit4 is 1 and inner descends when bit2 XOR bit3 is 1.
- R5: Prefix pattern (bit0=0): row i emits j=0..i and p=i. This requires A<=B.
- R6: In the prefix pattern, bit3 (mirror X) makes a row of length L emit j=B-L..B-1 in ascending order.
- R7: In the prefix pattern, bit4 (mirror Y) gives row i length B-i instead of i+1.
- R8: In the prefix pattern, bit2 visits the rows in the order i=A-1 down to 0.
- R9: `inner_last` is 1 exactly on the last triple of each row.
- R10: `done` is 1 together with the final triple and stays 1 until `start`. A `step` after the final triple drops `valid`.
- R11: The word is unsupported, giving no triples and `done`=1 right after `start`, when any of these holds:
  - the pattern class is not 2'b10;
  - the select bit is 0;
  - the prefix pattern is used with bit1=1;
  - the prefix pattern is used with A>B.
- R12: While `step` is 0, the triple and `valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | latch `shape`, rewind counters |
| step | input | 1 | advance one triple |
| shape | input | 2*DW+8 | configuration word |
| a_idx | output | DW | A element index |
| b_idx | output | DW | B element index |
| p_idx | output | DW+1 | product/accumulator element index |
| valid | output | 1 | triple is meaningful |
| inner_last | output | 1 | last triple of a row |
| done | output | 1 | final triple reached or sequence over |

## Verification
The assertions assume that `shape` matters only in the cycle where `start` is high. They also assume that `start` and `step` are ordinary synchronous levels with no meaning during reset. The stimulus changes every input on the falling clock edge, pulses `start` for a single cycle, and leaves `shape` unchanged for the rest of a sequence. `step` is held low on random cycles to exercise holding, and is kept high past the end of each sequence to exercise the idle state.

// File: rtl/bigmul_remap_seq.sv
module bigmul_remap_seq #(
  parameter int DW = 6,
  localparam int SW = 2*DW + 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [SW-1:0] shape,
  output logic [DW-1:0] a_idx,
  output logic [DW-1:0] b_idx,
  output logic [DW:0]   p_idx,
  output logic          valid,
  output logic          inner_last,
  output logic          done
);

  logic [DW-1:0] a_m1, b_m1, oc, ic, ii, jj, len_m1;
  logic [4:0]    sub;
  logic          run, fin;

  logic          bm, irev, jrev, row_end, all_end, ok;
  logic [DW:0]   bsz, sum;

  logic [DW-1:0] sh_a, sh_b;
  logic [4:0]    sh_sub;
  assign sh_a   = shape[DW-1:0];
  assign sh_b   = shape[2*DW-1:DW];
  assign sh_sub = shape[2*DW+4:2*DW];
  assign ok = (shape[2*DW+6:2*DW+5] == 2'b10) && shape[2*DW+7] &&
              (sh_sub[0] || (!sh_sub[1] && sh_a <= sh_b));

  assign bm   = sub[0];
  assign irev = bm ? (sub[2] ^ sub[4]) : sub[2];
  assign jrev = bm & (sub[2] ^ sub[3]);
  assign ii   = irev ? (a_m1 - oc) : oc;
  assign len_m1 = bm ? b_m1 : (sub[4] ? (b_m1 - ii) : ii);
  assign jj   = bm ? (jrev ? (b_m1 - ic) : ic)
                   : (sub[3] ? (b_m1 - len_m1 + ic) : ic);
  assign bsz  = {1'b0, b_m1} + 1'b1;
  assign sum  = {1'b0, ii} + {1'b0, jj};

  assign row_end = (ic == len_m1);
  assign all_end = row_end && (oc == a_m1);

  always_comb begin
    if (!bm)        p_idx = {1'b0, ii};
    else if (sub[1]) p_idx = sum % bsz;
    else            p_idx = sum;
  end

  assign a_idx      = ii;
  assign b_idx      = jj;
  assign valid      = run;
  assign inner_last = run & row_end;
  assign done       = fin | (run & all_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; fin <= 1'b0;
      oc <= '0; ic <= '0;
      a_m1 <= '0; b_m1 <= '0; sub <= '0;
    end else if (start) begin
      a_m1 <= sh_a; b_m1 <= sh_b; sub <= sh_sub;
      oc <= '0; ic <= '0;
      run <= ok; fin <= !ok;
    end else if (run && step) begin
      if (row_end) begin
        ic <= '0;
        if (oc == a_m1) begin
          run <= 1'b0; fin <= 1'b1;
        end else begin
          oc <= oc + 1'b1;
        end
      end else begin
        ic <= ic + 1'b1;
      end
    end
  end

  a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    inner_last |-> valid);
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (a_idx <= a_m1) && (b_idx <= b_m1));
  a_r3_mod_below_b: assert property (@(posedge clk) disable iff (!rst_n)
    valid && sub[0] && sub[1] |-> p_idx < bsz);
  a_r5_prefix_row: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !sub[0] |-> p_idx == {1'b0, a_idx});
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && step && !start |=> !valid);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !step && !start |=> valid && $stable(a_idx) && $stable(b_idx) && $stable(p_idx));

endmodule

// File: tb/bigmul_remap_seq_test.sv
module bigmul_remap_seq_test;
  localparam int DW = 6;
  localparam int SW = 2*DW + 8;

  logic clk = 0, rst_n = 0, start = 0, step = 0;
  logic [SW-1:0] shape = '0;
  logic [DW-1:0] a_idx, b_idx;
  logic [DW:0]   p_idx;
  logic valid, inner_last, done;

  int checks = 0, fails = 0;
  int qa[$], qb[$], qp[$], ql[$];

  always #4 clk = ~clk;

  bigmul_remap_seq #(.DW(DW)) uut (.clk, .rst_n, .start, .step, .shape,
    .a_idx, .b_idx, .p_idx, .valid, .inner_last, .done);

  task automatic chk(string tag, bit good, string what);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic build(int A, int B, int sub, bit supported);
    bit bmul, ir, jr;
    qa.delete(); qb.delete(); qp.delete(); ql.delete();
    if (!supported) return;
    bmul = sub[0];
    ir = bmul ? (sub[2] ^ sub[4]) : sub[2];
    jr = bmul & (sub[2] ^ sub[3]);
    for (int o = 0; o < A; o++) begin
      int i = ir ? A-1-o : o;
      int len = bmul ? B : (sub[4] ? B-i : i+1);
      for (int c = 0; c < len; c++) begin
        int j, p;
        if (bmul) begin
          j = jr ? B-1-c : c;
          p = sub[1] ? (i+j) % B : i+j;
        end else begin
          j = sub[3] ? B-len+c : c;
          p = i;
        end
        qa.push_back(i); qb.push_back(j); qp.push_back(p); ql.push_back(c == len-1);
      end
    end
  endtask

  task automatic run_case(string tag, int A, int B, int sub, int cls, int z);
    bit sup = (cls == 2) && (z == 1) && (sub[0] || (!sub[1] && A <= B));
    int n, idx;
    build(A, B, sub, sup);
    n = qa.size();
    @(negedge clk);
    shape = {z[0], cls[1:0], sub[4:0], 6'(B-1), 6'(A-1)};
    start = 1; step = 0;
    @(negedge clk);
    start = 0;
    idx = 0;
    while (idx < n) begin
      bit st;
      chk(tag, valid === 1 && a_idx === DW'(qa[idx]) && b_idx === DW'(qb[idx]) &&
          p_idx === (DW+1)'(qp[idx]) && inner_last === ql[idx][0] && done === (idx == n-1),
          $sformatf("elem %0d got v%0b a%0d b%0d p%0d l%0b d%0b exp a%0d b%0d p%0d l%0d d%0b",
            idx, valid, a_idx, b_idx, p_idx, inner_last, done,
            qa[idx], qb[idx], qp[idx], ql[idx], idx == n-1));
      st = ($urandom % 4) != 0;
      step = st;
      @(negedge clk);
      if (st) idx++;
    end
    step = 1;
    for (int k = 0; k < 3; k++) begin
      chk(sup ? "R10" : "R11", valid === 0 && done === 1,
          $sformatf("idle got v%0b d%0b exp v0 d1", valid, done));
      @(negedge clk);
    end
    step = 0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL R10: watchdog expired got hang exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", valid === 0 && done === 0, $sformatf("reset got v%0b d%0b exp 0 0", valid, done));
    rst_n = 1;
    @(negedge clk);
    chk("R1", valid === 0 && done === 0, $sformatf("idle got v%0b d%0b exp 0 0", valid, done));
    run_case("R2",  3, 4, 5'b00001, 2, 1);
    run_case("R2",  1, 1, 5'b00001, 2, 1);
    run_case("R3",  4, 4, 5'b00011, 2, 1);
    run_case("R3",  5, 3, 5'b00011, 2, 1);
    run_case("R4",  3, 4, 5'b00101, 2, 1);
    run_case("R4",  3, 4, 5'b01101, 2, 1);
    run_case("R4",  3, 4, 5'b10101, 2, 1);
    run_case("R4",  3, 5, 5'b11001, 2, 1);
    run_case("R5",  4, 4, 5'b00000, 2, 1);
    run_case("R6",  4, 6, 5'b01000, 2, 1);
    run_case("R7",  4, 4, 5'b10000, 2, 1);
    run_case("R7",  4, 4, 5'b11000, 2, 1);
    run_case("R8",  3, 5, 5'b00100, 2, 1);
    run_case("R9",  2, 64, 5'b00001, 2, 1);
    run_case("R12", 64, 2, 5'b00011, 2, 1);
    run_case("R11", 3, 3, 5'b00001, 1, 1);
    run_case("R11", 3, 3, 5'b00001, 2, 0);
    run_case("R11", 3, 3, 5'b00010, 2, 1);
    run_case("R11", 5, 3, 5'b00000, 2, 1);
    run_case("R1",  2, 2, 5'b00001, 2, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule